// File: doc/BRIEF.md
# Two-Wire Shared-Data SPI Master

This block is an SPI master that reaches an ordinary SPI slave through only two pins: a clock output and one shared, bidirectional data pad. The block has no chip-select output. An external RC low-pass network on the clock pin produces chip select, so the block sets the clock's duty cycle and its idle time to control that signal. While bits are moving, the clock is high for one quarter of each bit time. The filtered level then stays low and the slave stays selected. At the end of a frame the clock is held high for a long programmable time, which lets the filtered level rise and deselect the slave.

Each bit time carries one read and one write on the same wire. The clock falls and the slave puts its next bit on the line. The master keeps its pad released for a settling window and then samples the line. Still in the low phase, it turns on its pad driver and drives its own bit over the slave's output. It releases the pad again when the clock rises, which is the edge on which the slave captures. Bytes move most significant bit first. On the user side there is a valid/ready transmit port and a receive port with a one-cycle strobe. A byte offered at the end of the previous byte continues the frame without a gap.

Top module: `twoWireSpiMaster`

## Requirements
- R1: While reset is asserted and afterwards until the first byte is accepted, the clock output is 1, the pad output enable is 0, rxValid is 0 and txReady is 1.
- R2: Inside a frame, every clock-low phase lasts exactly 3*HIGH_CYC system cycles and every clock-high phase between two bits of the same frame lasts exactly HIGH_CYC cycles.
- R3: For the first SETTLE_CYC cycles of every clock-low phase the pad enable is 0. For the remaining 3*HIGH_CYC-SETTLE_CYC cycles of that phase it is 1. It is 0 in every cycle in which the clock output is 1.
- R4: The master samples the shared line on the last cycle of the settling window, so the slave's bit (changed after the falling edge) is received.
- R5: Transmit bits appear on the pad most significant bit first, one per bit time. The slave capturing on each rising clock edge receives exactly the transmit byte.
- R6: After the eighth sample, rxData holds the eight received bits with the first bit received as bit 7. rxValid is 1 for exactly one cycle.
- R7: When no byte is accepted at the end of a byte, the clock stays 1 for at least HIGH_CYC+IDLE_CYC cycles before the next falling edge. During that tail txReady is 0, even if txValid is 1.
- R8: A byte offered while the last high phase of the previous byte ends is accepted there. The next falling edge follows after exactly HIGH_CYC high cycles, with no idle tail.
- R9: A byte accepted in the idle state produces a falling clock edge in the cycle right after the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| txData | input | DATA_W | Byte to send |
| txValid | input | 1 | txData is offered |
| txReady | output | 1 | Block takes txData on this cycle if txValid |
| rxData | output | DATA_W | Last received byte |
| rxValid | output | 1 | One-cycle strobe, rxData is new |
| sclkOut | output | 1 | Line clock; its filtered level is chip select |
| padOut | output | 1 | Data pad output value |
| padOe | output | 1 | Data pad driver enable |
| padIn | input | 1 | Data pad input value |

## Verification
A bench slave model shares the line with the master: the master wins when it drives, and otherwise the line follows the slave. All 256 transmit values are sent as separate frames, each paired with a different slave byte, so that every bit position is checked with both polarities in both directions. Between those frames the next byte is offered during the idle tail, which separates "waits out the tail" from "starts early". A burst of continuous bytes follows, which separates the no-gap continuation from the end-of-frame idle. Every low and high phase is timed, and the pad enable is checked cycle by cycle against its window.

// File: rtl/twsmPkg.sv
package twsmPkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_DRIVE  = 3'd2,
    ST_HIGH   = 3'd3,
    ST_TAIL   = 3'd4
  } twsmState_t;

  // strobes and line levels from control to datapath
  typedef struct packed {
    logic load;      // take txData into the transmit shifter
    logic shift;     // advance transmit shifter to next bit
    logic sample;    // capture padIn into the receive shifter
    logic lastBit;   // current bit is the final one of the byte
    logic sclkLvl;   // clock pin level
    logic oeLvl;     // pad driver enable level
  } twsmStrobes_t;

endpackage

// File: rtl/twsmCtrl.sv
module twsmCtrl
  import twsmPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int HIGH_CYC   = 2,
  parameter int SETTLE_CYC = 3,
  parameter int IDLE_CYC   = 20
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         txValid,
  output logic         txReady,
  output twsmStrobes_t strobes
);

  localparam int DRIVE_CYC = 3 * HIGH_CYC - SETTLE_CYC;
  localparam int MAX_A     = (HIGH_CYC > SETTLE_CYC) ? HIGH_CYC : SETTLE_CYC;
  localparam int MAX_B     = (DRIVE_CYC > IDLE_CYC) ? DRIVE_CYC : IDLE_CYC;
  localparam int CNT_MAX   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam int BIT_W     = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  twsmState_t stateQ;
  logic [CNT_W-1:0] cntQ;
  logic [BIT_W-1:0] bitQ;

  logic cntDone;
  logic lastBit;
  logic endOfByte;

  always_comb begin
    cntDone   = (cntQ == '0);
    lastBit   = (bitQ == BIT_W'(DATA_W - 1));
    endOfByte = (stateQ == ST_HIGH) && cntDone && lastBit;
    txReady   = (stateQ == ST_IDLE) || endOfByte;

    strobes         = '0;
    strobes.load    = txReady && txValid;
    strobes.shift   = (stateQ == ST_HIGH) && cntDone && !lastBit;
    strobes.sample  = (stateQ == ST_SETTLE) && cntDone;
    strobes.lastBit = lastBit;
    strobes.sclkLvl = (stateQ == ST_IDLE) || (stateQ == ST_HIGH) || (stateQ == ST_TAIL);
    strobes.oeLvl   = (stateQ == ST_DRIVE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      bitQ   <= '0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (txValid) begin
            stateQ <= ST_SETTLE;
            cntQ   <= CNT_W'(SETTLE_CYC - 1);
            bitQ   <= '0;
          end
        end
        ST_SETTLE: begin
          if (cntDone) begin
            stateQ <= ST_DRIVE;
            cntQ   <= CNT_W'(DRIVE_CYC - 1);
          end else begin
            cntQ <= cntQ - 1'b1;
          end
        end
        ST_DRIVE: begin
          if (cntDone) begin
            stateQ <= ST_HIGH;
            cntQ   <= CNT_W'(HIGH_CYC - 1);
          end else begin
            cntQ <= cntQ - 1'b1;
          end
        end
        ST_HIGH: begin
          if (!cntDone) begin
            cntQ <= cntQ - 1'b1;
          end else if (!lastBit) begin
            stateQ <= ST_SETTLE;
            cntQ   <= CNT_W'(SETTLE_CYC - 1);
            bitQ   <= bitQ + 1'b1;
          end else if (txValid) begin
            stateQ <= ST_SETTLE;
            cntQ   <= CNT_W'(SETTLE_CYC - 1);
            bitQ   <= '0;
          end else begin
            stateQ <= ST_TAIL;
            cntQ   <= CNT_W'(IDLE_CYC - 1);
          end
        end
        ST_TAIL: begin
          if (cntDone) begin
            stateQ <= ST_IDLE;
          end else begin
            cntQ <= cntQ - 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/twsmDatapath.sv
module twsmDatapath
  import twsmPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  twsmStrobes_t      strobes,
  input  logic [DATA_W-1:0] txData,
  input  logic              padIn,
  output logic              padOut,
  output logic              padOe,
  output logic              sclkOut,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid
);

  logic [DATA_W-1:0] txShiftQ;
  logic [DATA_W-1:0] rxShiftQ;
  logic [DATA_W-1:0] rxNext;

  assign rxNext  = {rxShiftQ[DATA_W-2:0], padIn};
  assign padOut  = txShiftQ[DATA_W-1];
  assign padOe   = strobes.oeLvl;
  assign sclkOut = strobes.sclkLvl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShiftQ <= '0;
    end else if (strobes.load) begin
      txShiftQ <= txData;
    end else if (strobes.shift) begin
      txShiftQ <= {txShiftQ[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShiftQ <= '0;
      rxData   <= '0;
      rxValid  <= 1'b0;
    end else begin
      rxValid <= strobes.sample && strobes.lastBit;
      if (strobes.sample) begin
        rxShiftQ <= rxNext;
        if (strobes.lastBit) begin
          rxData <= rxNext;
        end
      end
    end
  end

endmodule

// File: rtl/twoWireSpiMaster.sv
module twoWireSpiMaster
  import twsmPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int HIGH_CYC   = 2,
  parameter int SETTLE_CYC = 3,
  parameter int IDLE_CYC   = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              sclkOut,
  output logic              padOut,
  output logic              padOe,
  input  logic              padIn
);

  twsmStrobes_t strobes;

  twsmCtrl #(
    .DATA_W    (DATA_W),
    .HIGH_CYC  (HIGH_CYC),
    .SETTLE_CYC(SETTLE_CYC),
    .IDLE_CYC  (IDLE_CYC)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .txValid (txValid),
    .txReady (txReady),
    .strobes (strobes)
  );

  twsmDatapath #(
    .DATA_W(DATA_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .txData  (txData),
    .padIn   (padIn),
    .padOut  (padOut),
    .padOe   (padOe),
    .sclkOut (sclkOut),
    .rxData  (rxData),
    .rxValid (rxValid)
  );

endmodule

// File: rtl/twsmChecker.sv
module twsmChecker #(
  parameter int DATA_W     = 8,
  parameter int HIGH_CYC   = 2,
  parameter int SETTLE_CYC = 3,
  parameter int IDLE_CYC   = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] txData,
  input logic              txValid,
  input logic              txReady,
  input logic [DATA_W-1:0] rxData,
  input logic              rxValid,
  input logic              sclkOut,
  input logic              padOut,
  input logic              padOe,
  input logic              padIn
);

  logic [15:0] lowRun;
  logic [15:0] highRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowRun  <= '0;
      highRun <= 16'(HIGH_CYC + IDLE_CYC);
    end else if (sclkOut) begin
      lowRun  <= '0;
      highRun <= (highRun == 16'hFFFF) ? highRun : highRun + 1'b1;
    end else begin
      highRun <= '0;
      lowRun  <= (lowRun == 16'hFFFF) ? lowRun : lowRun + 1'b1;
    end
  end

  AST_LOW_PHASE_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclkOut) |-> (lowRun == 16'(3 * HIGH_CYC))); // R2

  AST_HIGH_PHASE_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclkOut) |-> (highRun >= 16'(HIGH_CYC))); // R2

  AST_OE_ONLY_IN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    padOe |-> !sclkOut); // R3

  AST_OE_OFF_AT_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclkOut) |-> !padOe); // R3

  AST_OE_RELEASE_AT_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(padOe) |-> sclkOut); // R3

  AST_RXVALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R6

  AST_ACCEPT_STARTS_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !sclkOut); // R9

  AST_READY_ONLY_CLK_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> sclkOut); // R7

endmodule

bind twoWireSpiMaster twsmChecker #(
  .DATA_W    (DATA_W),
  .HIGH_CYC  (HIGH_CYC),
  .SETTLE_CYC(SETTLE_CYC),
  .IDLE_CYC  (IDLE_CYC)
) uChk (.*);

// File: tb/tb_twoWireSpiMaster.sv
module tb_twoWireSpiMaster;

  localparam int DATA_W     = 8;
  localparam int HIGH_CYC   = 2;
  localparam int SETTLE_CYC = 3;
  localparam int IDLE_CYC   = 20;
  localparam int MAX_BYTES  = 512;
  localparam int BURST_LEN  = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DATA_W-1:0] txData = '0;
  logic txValid = 1'b0;
  logic txReady;
  logic [DATA_W-1:0] rxData;
  logic rxValid;
  logic sclkOut;
  logic padOut;
  logic padOe;
  logic padIn;
  logic slaveOut = 1'b1;

  // master overrides the slave whenever its driver is on
  assign padIn = padOe ? padOut : slaveOut;

  always #5 clk = ~clk;

  twoWireSpiMaster #(
    .DATA_W(DATA_W), .HIGH_CYC(HIGH_CYC), .SETTLE_CYC(SETTLE_CYC), .IDLE_CYC(IDLE_CYC)
  ) dut (
    .clk(clk), .rstN(rstN), .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxValid(rxValid), .sclkOut(sclkOut), .padOut(padOut),
    .padOe(padOe), .padIn(padIn)
  );

  int nChecks = 0;
  int nFails  = 0;
  logic [DATA_W-1:0] masterTx [MAX_BYTES];
  logic [DATA_W-1:0] slaveTx  [MAX_BYTES];
  int nSent = 0;
  int rxIdx = 0;
  int capIdx = 0;
  int slLoadIdx = 0;
  bit expectLong = 1'b1;
  bit observe = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // slave model and line-timing observer, all sampled at falling system edge
  logic prevSclk = 1'b1;
  logic prevLine = 1'b1;
  logic prevRxValid = 1'b0;
  int hiCnt = 1000;
  int lowCnt = 0;
  int slBit = 0;
  logic [DATA_W-1:0] slShift = '0;
  logic [DATA_W-1:0] slRx = '0;

  always @(negedge clk) begin
    if (observe) begin
      if (prevSclk && !sclkOut) begin
        if (expectLong)
          check(hiCnt >= HIGH_CYC + IDLE_CYC || slBit != 0, "R7 idle tail length", hiCnt, HIGH_CYC + IDLE_CYC);
        else
          check(hiCnt == HIGH_CYC || slBit == 0, "R2 in-frame high length", hiCnt, HIGH_CYC);
        if (slBit != 0)
          check(hiCnt == HIGH_CYC, "R2 in-frame high length", hiCnt, HIGH_CYC);
        else if (!expectLong)
          check(hiCnt == HIGH_CYC, "R8 back-to-back gap", hiCnt, HIGH_CYC);
        if (slBit == 0) begin
          slShift = slaveTx[slLoadIdx];
          slLoadIdx++;
        end
        slaveOut = slShift[DATA_W-1];
        slShift = {slShift[DATA_W-2:0], 1'b0};
        lowCnt = 1;
      end else if (!sclkOut) begin
        lowCnt++;
      end
      if (!sclkOut) begin
        check(padOe == (lowCnt > SETTLE_CYC), "R3 enable window", int'(padOe), int'(lowCnt > SETTLE_CYC));
      end else begin
        if (padOe) check(1'b0, "R3 enable while clock high", 1, 0);
      end
      if (!prevSclk && sclkOut) begin
        check(lowCnt == 3 * HIGH_CYC, "R2 low length", lowCnt, 3 * HIGH_CYC);
        slRx = {slRx[DATA_W-2:0], prevLine};
        slBit++;
        if (slBit == DATA_W) begin
          check(slRx == masterTx[capIdx], "R5 slave received byte", int'(slRx), int'(masterTx[capIdx]));
          capIdx++;
          slBit = 0;
        end
        hiCnt = 1;
      end else if (sclkOut) begin
        hiCnt++;
      end
      if (rxValid) begin
        check(!prevRxValid, "R6 strobe width", 1, 0);
        check(rxData == slaveTx[rxIdx], "R4 R6 master received byte", int'(rxData), int'(slaveTx[rxIdx]));
        rxIdx++;
      end
    end
    prevRxValid = rxValid;
    prevSclk = sclkOut;
    prevLine = padIn;
  end

  task automatic sendByte(input logic [DATA_W-1:0] m, input logic [DATA_W-1:0] s, input bit longGap);
    expectLong = longGap;
    masterTx[nSent] = m;
    slaveTx[nSent] = s;
    nSent++;
    txData = m;
    txValid = 1'b1;
    while (!txReady) @(negedge clk);
    @(negedge clk);
    if (longGap) check(sclkOut == 1'b0, "R9 fall after accept", int'(sclkOut), 0);
    txValid = 1'b0;
    @(negedge clk);
  endtask

  // watchdog
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check(sclkOut == 1'b1, "R1 reset clock", int'(sclkOut), 1);
    check(padOe == 1'b0, "R1 reset enable", int'(padOe), 0);
    check(rxValid == 1'b0, "R1 reset strobe", int'(rxValid), 0);
    check(txReady == 1'b1, "R1 reset ready", int'(txReady), 1);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(sclkOut == 1'b1 && padOe == 1'b0, "R1 idle after reset", int'({sclkOut, padOe}), 2);
    observe = 1'b1;

    // separate frames: every transmit value, the next byte offered inside the tail
    for (int i = 0; i < 256; i++) begin
      sendByte(DATA_W'(i), DATA_W'((i * 37 + 91) & 8'hFF), 1'b1);
      while (!rxValid) @(negedge clk);
      repeat (4 * HIGH_CYC + 1) @(negedge clk);
      check(txReady == 1'b0 && sclkOut == 1'b1, "R7 ready low in tail", int'(txReady), 0);
    end
    repeat (HIGH_CYC + IDLE_CYC + 4) @(negedge clk);

    // continuous burst within one frame
    for (int i = 0; i < BURST_LEN; i++) begin
      sendByte(DATA_W'((i * 7 + 3) & 8'hFF), DATA_W'(~((i * 13 + 5) & 8'hFF)), i == 0);
    end
    while (capIdx < nSent || rxIdx < nSent) @(negedge clk);
    repeat (HIGH_CYC + IDLE_CYC + 4) @(negedge clk);
    check(rxIdx == nSent, "R6 strobe count", rxIdx, nSent);
    check(capIdx == nSent, "R5 slave byte count", capIdx, nSent);
    check(sclkOut == 1'b1 && padOe == 1'b0 && txReady == 1'b1, "R7 idle after frame",
          int'({sclkOut, padOe, txReady}), 5);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule